// File: doc/BRIEF.md
# Three-Input Arrival Order Detector

This block watches three single-bit event inputs that start low after reset. Each one rises once and then stays high. The block works out the order in which they rose. It runs on a clock. Each input passes through a two-flop synchronizer, and a rising edge is taken as the synchronized level high while the previous synchronized sample was low.

When one input rises alone in a cycle, the block captures the synchronized levels of the other two inputs. That input's rank then follows from how many of the captured bits are high. A small phase machine counts accepted arrivals and drives two flags. The first, order known, rises once two inputs have arrived, because the position of the last input is then fixed. The second, all arrived, rises once the third input has arrived. If two or more inputs are seen rising in the same cycle, their order cannot be told apart. The block then sets a sticky error flag and leaves both the captures and the phase as they were.

The phase machine has four states. IDLE means nothing has arrived. ONE means one input has arrived. TWO means the order is known. ALL means every input has arrived. Its transitions are:
- FIRST_ARRIVAL moves IDLE to ONE.
- SECOND_ARRIVAL moves ONE to TWO.
- THIRD_ARRIVAL moves TWO to ALL.
- DROP_TO_IDLE moves any state back to IDLE when all three synchronized levels are low.
- HOLD keeps the state when no single rise is seen, or when several inputs rise together.

Top module: `arrival_order`

## Requirements
- R1: A synchronous active-high reset clears every rank field to 2'b00, clears order known, all arrived and the error flag, and clears the synchronizers.
- R2: An input that rises alone while the other two are low gets rank 2'b01 (first). Rank of input i sits at rank_o[2i+1:2i].
- R3: An input that rises alone while exactly one other input is high gets rank 2'b10 (second).
- R4: An input that rises alone while both other inputs are high gets rank 2'b11 (third). An input that has not been accepted reports 2'b00.
- R5: Order known is low after the first accepted arrival and rises with the second accepted arrival.
- R6: All arrived is low until the third accepted arrival and rises with it.
- R7: An input change driven before clock edge k shows on the outputs just after edge k+2 and not after edge k+1.
- R8: When two or more inputs rise in the same cycle, the error flag rises. The ranks, order known and all arrived keep their previous values.
- R9: Once set, the error flag stays high through later arrivals and through a return to idle, until reset.
- R10: When all three inputs are seen low without a reset, every rank returns to 2'b00 and both flags fall. The error flag is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 3 | Event inputs, one bit per input |
| rank_o | output | 6 | Rank of each input, 2 bits per input, input i at [2i+1:2i] |
| order_known_o | output | 1 | Two inputs have arrived |
| all_arrived_o | output | 1 | All three inputs have arrived |
| double_rise_o | output | 1 | Sticky flag: several inputs rose in one cycle |

## Verification
All six arrival permutations are applied with different spacings between rises. Because every input takes every rank, a swapped or misrouted capture bit shows as a wrong rank, and both flags are checked after each step. Directed cases cover two inputs rising together from idle and after one arrival, which separates error handling from order tracking. They also cover a drop of all inputs without reset, which tests the return to idle while the error stays set, and a reset in the middle of a sequence. One step is sampled on both sides of the expected output edge to pin the latency.

// File: rtl/arrival_order_pkg.sv
package arrival_order_pkg;
    localparam int NUM_IN = 3;
    localparam int RANK_W = $clog2(NUM_IN + 1);

    localparam logic [RANK_W-1:0] RANK_NONE = '0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_ALL  = 2'd3
    } phase_e;

    function automatic logic [RANK_W-1:0] rank_from_capture(input logic [NUM_IN-1:0] cap);
        logic [RANK_W-1:0] cnt;
        cnt = RANK_W'(1);
        for (int k = 0; k < NUM_IN; k++) begin
            cnt = cnt + RANK_W'(cap[k]);
        end
        return cnt;
    endfunction
endpackage

// File: rtl/ao_sync.sv
module ao_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign level_o = stage_q[STAGES-1];
    assign rise_o  = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ao_phase_fsm.sv
module ao_phase_fsm
    import arrival_order_pkg::*;
#(
    parameter int WIDTH = NUM_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] rise_i,
    output logic             accept_o,
    output logic             clear_o,
    output logic             order_known_o,
    output logic             all_arrived_o,
    output logic             double_rise_o
);
    phase_e state_q, state_d;
    logic   multi;

    assign multi    = (rise_i & (rise_i - WIDTH'(1))) != '0;
    assign accept_o = (rise_i != '0) && !multi;
    assign clear_o  = (level_i == '0);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear_o) begin
            state_d = ST_IDLE;
        end else if (accept_o) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ONE;
                ST_ONE:  state_d = ST_TWO;
                ST_TWO:  state_d = ST_ALL;
                ST_ALL:  state_d = ST_ALL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            order_known_o <= 1'b0;
            all_arrived_o <= 1'b0;
            double_rise_o <= 1'b0;
        end else begin
            order_known_o <= (state_d == ST_TWO) || (state_d == ST_ALL);
            all_arrived_o <= (state_d == ST_ALL);
            if (multi) double_rise_o <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        double_rise_o |=> double_rise_o); // R9
    AST_MULTI_HOLDS: assert property (@(posedge clk) disable iff (rst)
        multi |=> $stable(state_q)); // R8
    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
        (accept_o && state_q == ST_IDLE) |=> (state_q == ST_ONE) && !order_known_o); // R5
    AST_ALL_LEVELS: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ALL) && (level_i != '0)) |-> (level_i == '1)); // R6
endmodule

// File: rtl/ao_rank.sv
module ao_rank
    import arrival_order_pkg::*;
#(
    parameter int WIDTH = NUM_IN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [WIDTH-1:0]        level_i,
    input  logic [WIDTH-1:0]        rise_i,
    input  logic                    accept_i,
    input  logic                    clear_i,
    output logic [WIDTH*RANK_W-1:0] rank_o
);
    logic [WIDTH-1:0] cap_q   [WIDTH];
    logic [WIDTH-1:0] arrived_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_in
        logic [WIDTH-1:0] others;
        assign others = level_i & ~(WIDTH'(1) << i);

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                cap_q[i]     <= '0;
                arrived_q[i] <= 1'b0;
            end else if (accept_i && rise_i[i]) begin
                cap_q[i]     <= others;
                arrived_q[i] <= 1'b1;
            end
        end

        assign rank_o[i*RANK_W +: RANK_W] =
            arrived_q[i] ? rank_from_capture(cap_q[i]) : RANK_NONE;

        AST_RANK_STABLE: assert property (@(posedge clk) disable iff (rst)
            (!clear_i && !(accept_i && rise_i[i])) |=> $stable(rank_o[i*RANK_W +: RANK_W])); // R8
    end
endmodule

// File: rtl/arrival_order.sv
module arrival_order
    import arrival_order_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IN-1:0]        evt_i,
    output logic [NUM_IN*RANK_W-1:0] rank_o,
    output logic                     order_known_o,
    output logic                     all_arrived_o,
    output logic                     double_rise_o
);
    logic [NUM_IN-1:0] level, rise;
    logic              accept, clear;

    ao_sync #(.WIDTH(NUM_IN), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (evt_i),
        .level_o (level),
        .rise_o  (rise)
    );

    ao_phase_fsm #(.WIDTH(NUM_IN)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .level_i       (level),
        .rise_i        (rise),
        .accept_o      (accept),
        .clear_o       (clear),
        .order_known_o (order_known_o),
        .all_arrived_o (all_arrived_o),
        .double_rise_o (double_rise_o)
    );

    ao_rank #(.WIDTH(NUM_IN)) u_rank (
        .clk      (clk),
        .rst      (rst),
        .level_i  (level),
        .rise_i   (rise),
        .accept_i (accept),
        .clear_i  (clear),
        .rank_o   (rank_o)
    );

    logic [1:0] n_ranked;
    logic [1:0] n_first;
    always_comb begin
        n_ranked = '0;
        n_first  = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (rank_o[i*RANK_W +: RANK_W] != RANK_NONE) n_ranked = n_ranked + 2'd1;
            if (rank_o[i*RANK_W +: RANK_W] == RANK_W'(1)) n_first = n_first + 2'd1;
        end
    end

    AST_KNOWN_TWO_RANKS: assert property (@(posedge clk) disable iff (rst)
        order_known_o |-> (n_ranked >= 2'd2)); // R5
    AST_ONE_FIRST: assert property (@(posedge clk) disable iff (rst)
        n_first <= 2'd1); // R2
    AST_ALL_KNOWN: assert property (@(posedge clk) disable iff (rst)
        all_arrived_o |-> order_known_o); // R6
endmodule

// File: tb/arrival_order_bench.sv
module arrival_order_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPERM = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evt_i = 3'b000;
    logic [5:0] rank_o;
    logic       order_known_o, all_arrived_o, double_rise_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // order encoding: [1:0] first input index, [3:2] second, [5:4] third
    localparam logic [5:0] PERM [NPERM] = '{
        {2'd2, 2'd1, 2'd0}, {2'd1, 2'd2, 2'd0}, {2'd2, 2'd0, 2'd1},
        {2'd0, 2'd2, 2'd1}, {2'd1, 2'd0, 2'd2}, {2'd0, 2'd1, 2'd2}
    };
    localparam int GAP [NPERM] = '{2, 5, 3, 9, 1, 12};

    always #(CLK_PERIOD/2) clk = ~clk;

    arrival_order u_arrival_order (
        .clk           (clk),
        .rst           (rst),
        .evt_i         (evt_i),
        .rank_o        (rank_o),
        .order_known_o (order_known_o),
        .all_arrived_o (all_arrived_o),
        .double_rise_o (double_rise_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        evt_i = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [1:0] rank_of(input logic [5:0] r, input int i);
        return r[i*2 +: 2];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 ranks after reset", 32'(rank_o), 0);
        check("R1 flags after reset", {order_known_o, all_arrived_o, double_rise_o}, 0);

        for (int p = 0; p < NPERM; p++) begin
            do_reset();
            for (int k = 0; k < 3; k++) begin
                int idx;
                idx = int'(PERM[p][k*2 +: 2]);
                @(negedge clk);
                evt_i[idx] = 1'b1;
                if (p == 0) begin
                    repeat (2) @(posedge clk);
                    @(negedge clk);
                    check("R7 not yet after second edge", 32'(rank_of(rank_o, idx)), 0);
                    @(posedge clk);
                    @(negedge clk);
                    check("R7 visible after third edge", 32'(rank_of(rank_o, idx)), 32'(k + 1));
                end else begin
                    settle();
                end
                repeat (GAP[p]) @(posedge clk);
                @(negedge clk);
                if (k == 0) check("R2 first rank", 32'(rank_of(rank_o, idx)), 1);
                if (k == 1) check("R3 second rank", 32'(rank_of(rank_o, idx)), 2);
                if (k == 2) check("R4 third rank", 32'(rank_of(rank_o, idx)), 3);
                if (k < 2)
                    check("R4 pending input rank none",
                          32'(rank_of(rank_o, int'(PERM[p][4 +: 2]))), 0);
                check("R5 order known", 32'(order_known_o), 32'(k >= 1));
                check("R6 all arrived", 32'(all_arrived_o), 32'(k == 2));
                check("R8 no error on single rises", 32'(double_rise_o), 0);
            end
        end

        // double rise from idle
        do_reset();
        @(negedge clk);
        evt_i = 3'b011;
        settle();
        check("R8 error on double rise", 32'(double_rise_o), 1);
        check("R8 ranks unchanged", 32'(rank_o), 0);
        check("R8 flags unchanged", {order_known_o, all_arrived_o}, 0);
        @(negedge clk);
        evt_i[2] = 1'b1;
        settle();
        check("R9 error held after later arrival", 32'(double_rise_o), 1);
        @(negedge clk);
        evt_i = 3'b000;
        settle();
        check("R10 ranks cleared on all low", 32'(rank_o), 0);
        check("R10 flags cleared on all low", {order_known_o, all_arrived_o}, 0);
        check("R9 error held through idle", 32'(double_rise_o), 1);
        do_reset();
        check("R1 reset clears error", 32'(double_rise_o), 0);

        // double rise after one arrival
        @(negedge clk);
        evt_i[2] = 1'b1;
        settle();
        @(negedge clk);
        evt_i = 3'b111;
        settle();
        check("R8 error after one arrival", 32'(double_rise_o), 1);
        check("R8 ranks kept", 32'(rank_o), 32'(6'b01_00_00));
        check("R8 order known kept low", 32'(order_known_o), 0);
        check("R8 all arrived kept low", 32'(all_arrived_o), 0);

        // return to idle after full sequence, then a new sequence
        do_reset();
        @(negedge clk); evt_i[1] = 1'b1; settle();
        @(negedge clk); evt_i[0] = 1'b1; settle();
        @(negedge clk); evt_i = 3'b000; settle();
        check("R10 idle ranks", 32'(rank_o), 0);
        check("R10 idle known", 32'(order_known_o), 0);
        @(negedge clk); evt_i[2] = 1'b1; settle();
        check("R10 new first after idle", 32'(rank_of(rank_o, 2)), 1);

        // reset in mid sequence
        @(negedge clk); evt_i[0] = 1'b1; settle();
        check("R5 known before reset", 32'(order_known_o), 1);
        do_reset();
        check("R1 mid-sequence reset ranks", 32'(rank_o), 0);
        check("R1 mid-sequence reset flags", {order_known_o, all_arrived_o, double_rise_o}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule